// File: doc/BRIEF.md
# UART Receive Byte Queue with Break Injection

This block holds received bytes for a UART between the bit-level deserializer and the register port that software reads. It stores up to four bytes and hands them out oldest first. A separate line monitor signals break conditions; each break is turned into a zero byte in the queue and latches a break-change interrupt flag, which stays set until the command path clears it.

The queue reports whether at least one byte is waiting (ready) and whether all four slots are taken (full). It also tells the deserializer whether a new data byte would be taken, which requires the receiver to be enabled and the queue not to be full. Data bytes offered while full are dropped, but a break arriving while full replaces the newest byte so that the break is never lost. The receiver-reset command drives a flush input that empties the queue at once.

Control is a three-state machine on the occupancy: `ST_EMPTY`, `ST_PART` (one to three bytes) and `ST_FULL`. Transitions: *fill* (`ST_EMPTY`→`ST_PART` on a push), *fill_last* (`ST_PART`→`ST_FULL` when the count reaches four), *drain* (`ST_FULL`→`ST_PART` on a read without a push), *drain_last* (`ST_PART`→`ST_EMPTY` when the last byte is read), *swap* (a push and a read together, or a break overwrite while full, leaving the state as it was), and *flush* (any state to `ST_EMPTY`). A break and a data byte in the same cycle: the break wins and the data byte is dropped.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the queue is empty: `rdy`, `full`, `brk_flag` and `can_accept` are 0 and `rd_byte` is 0x00.
- R2: Reads return bytes in arrival order; `rd_byte` shows the oldest byte while `rd_req` is high and the byte is removed at that clock edge.
- R3: Any accepted push (data or break) makes `rdy` 1 from the next cycle.
- R4: `full` is 1 exactly when four bytes are held and is never 1 while `rdy` is 0.
- R5: A data push (`wr_valid`) while full is dropped; the held bytes and flags are unchanged.
- R6: `brk_evt` pushes the byte 0x00 and sets `brk_flag` on the next cycle; `brk_clr` clears the flag, and a break in the same cycle as `brk_clr` leaves it set. Flush does not touch the flag.
- R7: A break while four bytes are held and no read is taken replaces the newest byte with 0x00; the count stays four and the three older bytes keep their order.
- R8: A read while empty shows 0x00 on `rd_byte` and changes no state.
- R9: A read of a full queue clears `full`; the read of the last byte clears `rdy`.
- R10: `can_accept` is 1 only while `rx_en` is 1 and the queue is not full; a data push while `rx_en` is 0 is dropped.
- R11: `flush` empties the queue and clears `rdy` and `full` on the next cycle, overriding any push or read in the same cycle.
- R12: A push and a read in the same cycle on a non-empty queue keep the count unchanged and append the new byte behind the remaining ones; on a full queue a data push in that cycle is still dropped, while a break is appended after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable level |
| wr_valid | input | 1 | Data byte offered by the deserializer this cycle |
| wr_byte | input | 8 | Data byte from the deserializer |
| brk_evt | input | 1 | One-cycle break event from the line monitor |
| rd_req | input | 1 | Register-port read of the receive data |
| flush | input | 1 | Receiver-reset command: empty the queue |
| brk_clr | input | 1 | Clear the break-change flag |
| rd_byte | output | 8 | Oldest held byte, 0x00 when empty |
| rdy | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |
| can_accept | output | 1 | A data push would be taken |
| brk_flag | output | 1 | Break-change interrupt flag |

## Verification
The assertions assume every input is a known level sampled at the rising edge and that `brk_evt`, `rd_req`, `flush` and `brk_clr` are single-cycle strobes whose effect is judged one cycle later; the bench changes inputs only on the falling edge and returns every strobe to 0 after one cycle. They also take for granted that a read counts only when `rd_req` is high across an edge, so the bench samples `rd_byte` just after driving the strobe and before that edge. The sweep brings the queue to every fill level from zero to four with rx_en both high and low and then applies every mix of data push, break and read, so the overwrite, the dropped data push and the simultaneous push-and-read paths are all reached.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } rxq_state_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (we && (wr_idx == PTR_W'(i))) begin
                slot[i] <= wr_data;
            end
        end
    end

    assign rd_data = slot[rd_idx];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             wr_valid,
    input  logic             brk_evt,
    input  logic             rd_req,
    input  logic             flush,
    output logic             we,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] head,
    output logic             nonempty,
    output logic             is_full,
    output logic             accept
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    rxq_state_e       st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [PTR_W-1:0] head_n;
    logic             pop, data_ok, push;

    assign pop     = rd_req && (st != ST_EMPTY);
    assign data_ok = wr_valid && rx_en && !brk_evt && (st != ST_FULL);
    assign push    = brk_evt || data_ok;

    // Overwrite slot is the newest entry; otherwise append behind the tail.
    always_comb begin
        if (st == ST_FULL && !pop) begin
            wr_idx = head + PTR_W'(cnt - 1'b1);
        end else begin
            wr_idx = head + PTR_W'(cnt);
        end
        we = push && !flush;
    end

    // Next-state process
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        head_n = head;
        if (flush) begin
            st_n   = ST_EMPTY;
            cnt_n  = '0;
            head_n = '0;
        end else begin
            if (pop) begin
                head_n = head + 1'b1;
            end
            if (push && !pop && st != ST_FULL) begin
                cnt_n = cnt + 1'b1;
            end else if (pop && !push) begin
                cnt_n = cnt - 1'b1;
            end
            unique case (st)
                ST_EMPTY: begin
                    if (push) st_n = ST_PART;
                end
                ST_PART: begin
                    if (cnt_n == CNT_MAX)  st_n = ST_FULL;
                    else if (cnt_n == '0)  st_n = ST_EMPTY;
                end
                ST_FULL: begin
                    if (cnt_n != CNT_MAX)  st_n = ST_PART;
                end
                default: st_n = ST_EMPTY;
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_EMPTY;
            cnt  <= '0;
            head <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            head <= head_n;
        end
    end

    // Output process
    always_comb begin
        nonempty = 1'b0;
        is_full  = 1'b0;
        unique case (st)
            ST_EMPTY: ;
            ST_PART:  nonempty = 1'b1;
            ST_FULL: begin
                nonempty = 1'b1;
                is_full  = 1'b1;
            end
            default: ;
        endcase
        accept = rx_en && !is_full;
    end
endmodule

// File: rtl/rxq_brkflag.sv
module rxq_brkflag (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_evt,
    input  logic brk_clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (brk_evt) begin
            flag <= 1'b1;
        end else if (brk_clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              brk_evt,
    input  logic              rd_req,
    input  logic              flush,
    input  logic              brk_clr,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rdy,
    output logic              full,
    output logic              can_accept,
    output logic              brk_flag
);
    logic              we;
    logic [PTR_W-1:0]  wr_idx, head;
    logic [DATA_W-1:0] wr_data, raw;
    logic              nonempty;

    // A break injects an all-zero byte.
    assign wr_data = brk_evt ? '0 : wr_byte;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_valid(wr_valid),
        .brk_evt(brk_evt), .rd_req(rd_req), .flush(flush),
        .we(we), .wr_idx(wr_idx), .head(head),
        .nonempty(nonempty), .is_full(full), .accept(can_accept)
    );

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(head), .rd_data(raw)
    );

    rxq_brkflag u_brk (
        .clk(clk), .rst_n(rst_n), .brk_evt(brk_evt), .brk_clr(brk_clr),
        .flag(brk_flag)
    );

    assign rdy     = nonempty;
    assign rd_byte = nonempty ? raw : '0;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic       brk_evt,
    input logic       rd_req,
    input logic       flush,
    input logic       brk_clr,
    input logic       rdy,
    input logic       full,
    input logic       brk_flag
);
    p_push_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && !flush) |=> rdy);

    p_full_has_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> rdy);

    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_req && !flush) |=> full);

    p_brk_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> brk_flag);

    p_brk_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr && !brk_evt) |=> !brk_flag);

    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && rd_req && !brk_evt && !wr_valid && !flush) |=> (!rdy && !full));

    p_read_clr_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_req && !brk_evt && !flush) |=> !full);

    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rdy && !full));

    p_brk_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !brk_clr && brk_flag) |=> brk_flag);
endmodule

bind rx_byte_queue rxq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .brk_evt(brk_evt),
    .rd_req(rd_req), .flush(flush), .brk_clr(brk_clr),
    .rdy(rdy), .full(full), .brk_flag(brk_flag)
);

// File: tb/sim_rx_byte_queue.sv
module sim_rx_byte_queue;
    logic       clk = 1'b0;
    logic       rst_n, rx_en, wr_valid, brk_evt, rd_req, flush, brk_clr;
    logic [7:0] wr_byte, rd_byte;
    logic       rdy, full, can_accept, brk_flag;

    int         total = 0;
    int         bad = 0;
    bit         done = 0;
    logic [7:0] mq[$];
    logic       mbrk = 1'b0;

    always #10 clk = ~clk;

    rx_byte_queue u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_valid(wr_valid),
        .wr_byte(wr_byte), .brk_evt(brk_evt), .rd_req(rd_req),
        .flush(flush), .brk_clr(brk_clr), .rd_byte(rd_byte), .rdy(rdy),
        .full(full), .can_accept(can_accept), .brk_flag(brk_flag)
    );

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; applies one cycle of stimulus and checks.
    task automatic step(input logic wv, input logic [7:0] wd, input logic br,
                        input logic rd, input logic fl, input logic cl,
                        input string tag);
        int sz;
        logic [7:0] exp_rd;
        logic pop, dok;
        wr_valid = wv; wr_byte = wd; brk_evt = br;
        rd_req = rd; flush = fl; brk_clr = cl;
        #1;
        sz = mq.size();
        exp_rd = (sz > 0) ? mq[0] : 8'h00;
        if (rd) chk(tag, "rd_byte", rd_byte, exp_rd);
        // reference model
        if (br) mbrk = 1'b1;
        else if (cl) mbrk = 1'b0;
        if (fl) begin
            mq.delete();
        end else begin
            pop = rd && (sz > 0);
            dok = wv && rx_en && !br && (sz < 4);
            if (pop) void'(mq.pop_front());
            if (br) begin
                if (sz == 4 && !pop) mq[3] = 8'h00;
                else mq.push_back(8'h00);
            end else if (dok) begin
                mq.push_back(wd);
            end
        end
        @(negedge clk);
        wr_valid = 0; brk_evt = 0; rd_req = 0; flush = 0; brk_clr = 0;
        #1;
        chk(tag, "rdy",  {7'b0, rdy},  {7'b0, mq.size() > 0});
        chk(tag, "full", {7'b0, full}, {7'b0, mq.size() == 4});
        chk(tag, "can_accept", {7'b0, can_accept}, {7'b0, rx_en && mq.size() < 4});
        chk(tag, "brk_flag", {7'b0, brk_flag}, {7'b0, mbrk});
    endtask

    task automatic drain(input string tag);
        while (mq.size() > 0) step(0, 8'h00, 0, 1, 0, 0, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rx_en = 0; wr_valid = 0; wr_byte = 0; brk_evt = 0;
        rd_req = 0; flush = 0; brk_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1", "rdy", {7'b0, rdy}, 8'h00);
        chk("R1", "full", {7'b0, full}, 8'h00);
        chk("R1", "brk_flag", {7'b0, brk_flag}, 8'h00);
        chk("R1", "can_accept", {7'b0, can_accept}, 8'h00);
        chk("R1", "rd_byte", rd_byte, 8'h00);
        @(negedge clk);

        // R10: disabled receiver drops data
        step(1, 8'h55, 0, 0, 0, 0, "R10");
        step(0, 8'h00, 0, 1, 0, 0, "R8");
        rx_en = 1;
        // R3/R4 fill, R5 overflow dropped, R2/R9 drain in order
        step(1, 8'hA1, 0, 0, 0, 0, "R3");
        step(1, 8'hA2, 0, 0, 0, 0, "R3");
        step(1, 8'hA3, 0, 0, 0, 0, "R4");
        step(1, 8'hA4, 0, 0, 0, 0, "R4");
        step(1, 8'hA5, 0, 0, 0, 0, "R5");
        step(0, 8'h00, 0, 1, 0, 0, "R9");
        drain("R2");
        step(0, 8'h00, 0, 1, 0, 0, "R8");
        // R6 break and clear, set wins
        step(0, 8'h00, 1, 0, 0, 0, "R6");
        step(0, 8'h00, 0, 0, 0, 1, "R6");
        step(0, 8'h00, 1, 0, 0, 1, "R6");
        drain("R6");
        // R7 break overwrite on full
        for (int k = 0; k < 4; k++) step(1, 8'hC0 + 8'(k), 0, 0, 0, 0, "R4");
        step(0, 8'h00, 1, 0, 0, 0, "R7");
        drain("R7");
        // R11 flush keeps flag, overrides push
        step(1, 8'h11, 0, 0, 0, 0, "R11");
        step(1, 8'h22, 1, 1, 1, 0, "R11");
        step(0, 8'h00, 0, 1, 0, 1, "R8");
        // R12 push and read together
        step(1, 8'h31, 0, 0, 0, 0, "R12");
        step(1, 8'h32, 0, 1, 0, 0, "R12");
        drain("R12");

        // Sweep: every fill level, enable level and push/break/read mix
        for (int en = 0; en < 2; en++) begin
            for (int fill = 0; fill <= 4; fill++) begin
                for (int op = 0; op < 8; op++) begin
                    string tag;
                    logic wv, br, rd;
                    wv = op[0]; br = op[1]; rd = op[2];
                    rx_en = 1;
                    step(0, 8'h00, 0, 0, 1, 1, "R11");
                    for (int k = 0; k < fill; k++)
                        step(1, 8'(fill * 16 + k + 1), 0, 0, 0, 0, "R3");
                    rx_en = logic'(en);
                    if (fill == 4 && br && !rd)            tag = "R7";
                    else if (rd && (wv || br) && fill > 0) tag = "R12";
                    else if (fill == 0 && rd)              tag = "R8";
                    else if (wv && !rx_en)                 tag = "R10";
                    else if (wv && fill == 4)              tag = "R5";
                    else                                   tag = "R2";
                    step(wv, 8'hE0 + 8'(op), br, rd, 0, 0, tag);
                    drain("R2");
                end
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule